// File: doc/BRIEF.md
# Reset Source Sequencer

This block produces the two reset levels of a small microcontroller system. The hard level (power-on reset) restarts everything. The soft level (power-up clear) restarts the processor and the peripherals but keeps a small set of sticky cause flags. Software reads those flags after restart to learn why the system went down.

Every hard cause also drives the soft level. The hard causes are:
- loss of power-good
- the external reset pin held low while it is in reset mode
- a supervisor low-voltage event while its reset enable is on

The soft causes are:
- a watchdog expiry while the watchdog is in watchdog mode
- any write with a wrong key byte to the watchdog control word or to one of the flash controller words
- an instruction fetch from the peripheral window or from the unimplemented hole in the address map

Both outputs are stretched by a counter and deassert on the clock. A small register port exposes the flag word and the pin mode bit.

Top module: `reset_sequencer`

## Requirements
- R1: While `pwr_good_i` is low, `por_o` and `puc_o` are high from the next clock edge. The flag word then reads 0x01: bit 0 is the power flag and every other bit is cleared.
- R2: `rst_pin_n_i` low raises `por_o` when the pin mode bit (bit 0 of the config word at `CFG_ADDR`) is 0. When that bit is 1, a low pin changes neither output.
- R3: `sv_low_i` raises `por_o` only while `sv_rst_en_i` is high. With the enable low it has no effect.
- R4: `puc_o` is high in every cycle in which `por_o` is high.
- R5: `wdt_expire_i` raises `puc_o`, and not `por_o`, only while `wdt_wdog_mode_i` is 1 (watchdog mode). In interval mode (0) it is ignored.
- R6: A write to `WDT_ADDR` whose bits [15:8] differ from 0x5A raises `puc_o`. A write with 0x5A in those bits raises nothing.
- R7: A write to any of the `FLASH_NUM` words starting at `FLASH_BASE` (stride 2) with bits [15:8] other than 0x5A raises `puc_o`. A write with the correct key raises nothing.
- R8: A valid fetch with address below `PERIPH_LIMIT`, or at or above `RAM_LIMIT` and below `CODE_BASE`, raises `puc_o`. Fetches elsewhere raise nothing.
- R9: A reset output rises at the first clock edge that samples its cause. After a cause lasting one cycle, the output stays high for exactly `HOLD` (4) sampled cycles and then falls.
- R10: Flag bit map: 0 power, 1 pin, 2 supervisor, 3 watchdog (expiry or key), 4 flash key, 5 illegal fetch. Each cause sets its bit one edge later. A soft reset clears no flag.
- R11: Writing a 1 to bit n at `FLAG_ADDR` clears flag n and leaves the other flags alone. If flag n is set in the same cycle, the set wins.
- R12: While `puc_o` is high, the pin mode bit returns to 0 (reset mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good_i | input | 1 | Power good; low is a power-up condition and the synchronous active-low reset |
| rst_pin_n_i | input | 1 | External reset pin, active low, already synchronized |
| sv_low_i | input | 1 | Supervisor low-voltage event |
| sv_rst_en_i | input | 1 | Allows the supervisor event to cause a hard reset |
| wdt_expire_i | input | 1 | Watchdog expiry strobe |
| wdt_wdog_mode_i | input | 1 | 1 = watchdog mode, 0 = interval mode |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W | Bus write address |
| wr_data_i | input | DATA_W | Bus write data; bits [15:8] carry the key |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | DATA_W | Flag word or config word, otherwise zero |
| fetch_valid_i | input | 1 | Instruction fetch strobe |
| fetch_addr_i | input | ADDR_W | Instruction fetch address |
| por_o | output | 1 | Hard reset level |
| puc_o | output | 1 | Soft reset level |

## Verification
Two functions can act on the same flag bit in one cycle. A cause can set the bit while a write-one-to-clear hits it. The bench drives a watchdog expiry in watchdog mode and a clearing write to bit 3 on the same clock edge, then reads the flag word and expects bit 3 to survive. A second overlap is a hard cause, which by itself loads the soft counter. For a pin reset the bench counts the high samples of both outputs and expects the counts to be equal.

// File: rtl/rst_seq_pkg.sv
// Shared constants for the reset sequencer: flag bit positions and key.
// Assumes flag positions are fixed because software decodes them.
package rst_seq_pkg;
    localparam int NSRC      = 6;
    localparam int SRC_PWR   = 0;
    localparam int SRC_PIN   = 1;
    localparam int SRC_SVS   = 2;
    localparam int SRC_WDT   = 3;
    localparam int SRC_FLASH = 4;
    localparam int SRC_FETCH = 5;
    localparam logic [7:0] DEF_KEY = 8'h5A;
    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/rst_cause_detect.sv
// Combinational decode of every reset cause into a hard request, a soft
// request and a per-source vector. Assumes all inputs are synchronous to
// the clock. The power-good cause is handled by the reset path, not here.
module rst_cause_detect
    import rst_seq_pkg::*;
#(
    parameter int              ADDR_W       = 16,
    parameter int              FLASH_NUM    = 3,
    parameter logic [7:0]      KEY          = DEF_KEY,
    parameter logic [ADDR_W-1:0] WDT_ADDR     = 16'h0120,
    parameter logic [ADDR_W-1:0] FLASH_BASE   = 16'h0128,
    parameter logic [ADDR_W-1:0] PERIPH_LIMIT = 16'h0200,
    parameter logic [ADDR_W-1:0] RAM_LIMIT    = 16'h0A00,
    parameter logic [ADDR_W-1:0] CODE_BASE    = 16'h1000
) (
    input  logic              rst_pin_n_i,
    input  logic              nmi_mode_i,
    input  logic              sv_low_i,
    input  logic              sv_rst_en_i,
    input  logic              wdt_expire_i,
    input  logic              wdt_wdog_mode_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_key_i,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic              hard_o,
    output logic              soft_o,
    output src_vec_t          src_o
);
    logic [FLASH_NUM-1:0] flash_hit;
    logic                 key_bad;
    logic                 fetch_bad;

    // One address comparator per protected flash controller word.
    for (genvar i = 0; i < FLASH_NUM; i++) begin : g_flash
        assign flash_hit[i] = wr_en_i && (wr_addr_i == FLASH_BASE + ADDR_W'(2 * i));
    end

    // Key check and address-map check.
    always_comb begin
        key_bad   = (wr_key_i != KEY);
        fetch_bad = fetch_valid_i &&
                    ((fetch_addr_i < PERIPH_LIMIT) ||
                     ((fetch_addr_i >= RAM_LIMIT) && (fetch_addr_i < CODE_BASE)));
    end

    // Gather the per-source causes and the two reset levels.
    always_comb begin
        src_o            = '0;
        src_o[SRC_PIN]   = !rst_pin_n_i && !nmi_mode_i;
        src_o[SRC_SVS]   = sv_low_i && sv_rst_en_i;
        src_o[SRC_WDT]   = (wdt_expire_i && wdt_wdog_mode_i) ||
                           (wr_en_i && (wr_addr_i == WDT_ADDR) && key_bad);
        src_o[SRC_FLASH] = (|flash_hit) && key_bad;
        src_o[SRC_FETCH] = fetch_bad;
        hard_o = src_o[SRC_PIN] | src_o[SRC_SVS];
        soft_o = src_o[SRC_WDT] | src_o[SRC_FLASH] | src_o[SRC_FETCH];
    end
endmodule

// File: rtl/rst_hold.sv
// Stretches a reset request. The output is high from the edge that
// samples the request until HOLD edges after the last such edge.
// Assumes rst_n is synchronous; the reset loads the counter as a request would.
module rst_hold #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause_i,
    output logic active_o
);
    localparam int CW = $clog2(HOLD + 1);
    logic [CW-1:0] cnt;

    // Reload on a request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || cause_i) cnt <= CW'(HOLD);
        else if (cnt != '0)    cnt <= cnt - CW'(1);
    end

    assign active_o = (cnt != '0);

    assert_hold_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cause_i |=> active_o);
    assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause_i && !active_o) |=> !active_o);
endmodule

// File: rtl/rst_status_regs.sv
// Sticky cause flags with write-one-to-clear, and the reset pin mode bit.
// Assumes rst_n is the power-good level. A soft reset keeps the flags
// and returns the pin to reset mode.
module rst_status_regs
    import rst_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     puc_i,
    input  src_vec_t set_i,
    input  logic     flag_wr_i,
    input  logic     cfg_wr_i,
    input  src_vec_t wdata_i,
    output src_vec_t flags_o,
    output logic     nmi_mode_o
);
    src_vec_t clr;

    // Clear mask from a flag-word write.
    always_comb clr = flag_wr_i ? wdata_i : '0;

    // Flags: power loss leaves only the power flag; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= src_vec_t'(1) << SRC_PWR;
        else        flags_o <= (flags_o & ~clr) | set_i;
    end

    // Pin mode: forced back to reset mode by any reset level.
    always_ff @(posedge clk) begin
        if (!rst_n || puc_i) nmi_mode_o <= 1'b0;
        else if (cfg_wr_i)   nmi_mode_o <= wdata_i[0];
    end

    for (genvar b = 0; b < NSRC; b++) begin : g_chk
        assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> flags_o[b]);
        assert_flag_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[b] && !clr[b]) |=> flags_o[b]);
    end

    assert_pin_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
        puc_i |=> !nmi_mode_o);
endmodule

// File: rtl/reset_sequencer.sv
// Top of the reset sequencer. It decodes the causes, stretches both reset
// levels and keeps the cause flags and the pin mode bit. pwr_good_i is the
// synchronous active-low reset and also the power-up cause.
module reset_sequencer
    import rst_seq_pkg::*;
#(
    parameter int              ADDR_W       = 16,
    parameter int              DATA_W       = 16,
    parameter int              HOLD         = 4,
    parameter int              FLASH_NUM    = 3,
    parameter logic [7:0]      KEY          = DEF_KEY,
    parameter logic [ADDR_W-1:0] WDT_ADDR     = 16'h0120,
    parameter logic [ADDR_W-1:0] FLASH_BASE   = 16'h0128,
    parameter logic [ADDR_W-1:0] FLAG_ADDR    = 16'h0130,
    parameter logic [ADDR_W-1:0] CFG_ADDR     = 16'h0132,
    parameter logic [ADDR_W-1:0] PERIPH_LIMIT = 16'h0200,
    parameter logic [ADDR_W-1:0] RAM_LIMIT    = 16'h0A00,
    parameter logic [ADDR_W-1:0] CODE_BASE    = 16'h1000
) (
    input  logic              clk,
    input  logic              pwr_good_i,
    input  logic              rst_pin_n_i,
    input  logic              sv_low_i,
    input  logic              sv_rst_en_i,
    input  logic              wdt_expire_i,
    input  logic              wdt_wdog_mode_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic              por_o,
    output logic              puc_o
);
    logic     hard_req, soft_req, nmi_mode, flag_wr, cfg_wr;
    src_vec_t src, flags;

    rst_cause_detect #(
        .ADDR_W(ADDR_W), .FLASH_NUM(FLASH_NUM), .KEY(KEY), .WDT_ADDR(WDT_ADDR),
        .FLASH_BASE(FLASH_BASE), .PERIPH_LIMIT(PERIPH_LIMIT),
        .RAM_LIMIT(RAM_LIMIT), .CODE_BASE(CODE_BASE)
    ) u_detect (
        .rst_pin_n_i(rst_pin_n_i), .nmi_mode_i(nmi_mode),
        .sv_low_i(sv_low_i), .sv_rst_en_i(sv_rst_en_i),
        .wdt_expire_i(wdt_expire_i), .wdt_wdog_mode_i(wdt_wdog_mode_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_key_i(wr_data_i[DATA_W-1 -: 8]),
        .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
        .hard_o(hard_req), .soft_o(soft_req), .src_o(src)
    );

    rst_hold #(.HOLD(HOLD)) u_por_hold (
        .clk(clk), .rst_n(pwr_good_i), .cause_i(hard_req), .active_o(por_o)
    );

    // Every hard request also loads the soft counter.
    rst_hold #(.HOLD(HOLD)) u_puc_hold (
        .clk(clk), .rst_n(pwr_good_i), .cause_i(hard_req | soft_req), .active_o(puc_o)
    );

    // Register-port write decode.
    always_comb begin
        flag_wr = wr_en_i && (wr_addr_i == FLAG_ADDR);
        cfg_wr  = wr_en_i && (wr_addr_i == CFG_ADDR);
    end

    rst_status_regs u_regs (
        .clk(clk), .rst_n(pwr_good_i), .puc_i(puc_o), .set_i(src),
        .flag_wr_i(flag_wr), .cfg_wr_i(cfg_wr), .wdata_i(wr_data_i[NSRC-1:0]),
        .flags_o(flags), .nmi_mode_o(nmi_mode)
    );

    // Register-port read mux.
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == FLAG_ADDR)     rd_data_o[NSRC-1:0] = flags;
        else if (rd_addr_i == CFG_ADDR) rd_data_o[0]        = nmi_mode;
    end

    assert_por_implies_puc_R4: assert property (@(posedge clk) disable iff (!pwr_good_i)
        por_o |-> puc_o);
    assert_wdt_key_R6: assert property (@(posedge clk) disable iff (!pwr_good_i)
        (wr_en_i && (wr_addr_i == WDT_ADDR) && (wr_data_i[DATA_W-1 -: 8] != KEY)) |=> puc_o);
    assert_interval_quiet_R5: assert property (@(posedge clk) disable iff (!pwr_good_i)
        (wdt_expire_i && !wdt_wdog_mode_i && !wr_en_i && !fetch_valid_i &&
         rst_pin_n_i && !sv_low_i && !puc_o) |=> !puc_o);
endmodule

// File: tb/reset_sequencer_tb.sv
module reset_sequencer_tb;
    logic        clk = 1'b0;
    logic        pwr_good_i = 1'b0, rst_pin_n_i = 1'b1, sv_low_i = 1'b0, sv_rst_en_i = 1'b0;
    logic        wdt_expire_i = 1'b0, wdt_wdog_mode_i = 1'b1, wr_en_i = 1'b0, fetch_valid_i = 1'b0;
    logic [15:0] wr_addr_i = '0, wr_data_i = '0, rd_addr_i = '0, fetch_addr_i = 16'hF000;
    logic [15:0] rd_data_o;
    logic        por_o, puc_o;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    localparam logic [15:0] A_WDT = 16'h0120, A_FL = 16'h0128, A_FLAG = 16'h0130, A_CFG = 16'h0132;

    always #2ns clk = ~clk;

    reset_sequencer u_dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Counts high samples of each output over six cycles after the edge that saw the cause.
    task automatic window(output int np, output int nq);
        np = 0; nq = 0;
        for (int i = 0; i < 6; i++) begin
            if (i > 0) @(negedge clk);
            #1; np += int'(por_o); nq += int'(puc_o);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk); wr_en_i = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        rd_addr_i = a; #1; d = rd_data_o;
    endtask

    task automatic t_power();
        logic [15:0] d;
        repeat (3) @(negedge clk);
        #1; check(por_o && puc_o, "R1 both high in reset", {por_o, puc_o}, 3);
        pwr_good_i = 1;
        repeat (8) @(negedge clk);
        #1; check(!por_o && !puc_o, "R1 released", {por_o, puc_o}, 0);
        rd(A_FLAG, d); check(d == 16'h0001, "R1 flags after power-up", d, 1);
    endtask

    task automatic t_wdt_key();
        int np, nq; logic [15:0] d;
        bus_write(A_FLAG, 16'h003F);
        bus_write(A_WDT, 16'h5A80); window(np, nq);
        check(nq == 0, "R6 good key", nq, 0);
        bus_write(A_WDT, 16'h3380); window(np, nq);
        check(nq == 4 && np == 0, "R6 R9 bad key stretch", {np, nq}, 4);
        rd(A_FLAG, d); check(d == 16'h0008, "R10 watchdog flag", d, 8);
    endtask

    task automatic t_wdt_expire();
        int np, nq;
        @(negedge clk); wdt_wdog_mode_i = 0; wdt_expire_i = 1;
        @(negedge clk); wdt_expire_i = 0; window(np, nq);
        check(nq == 0, "R5 interval mode ignored", nq, 0);
        wdt_wdog_mode_i = 1;
        @(negedge clk); wdt_expire_i = 1;
        @(negedge clk); wdt_expire_i = 0; window(np, nq);
        check(nq == 4 && np == 0, "R5 watchdog mode soft only", {np, nq}, 4);
    endtask

    task automatic t_flash();
        int np, nq; logic [15:0] d;
        bus_write(A_FLAG, 16'h003F);
        bus_write(A_FL + 16'd2, 16'h5A00); window(np, nq);
        check(nq == 0, "R7 good key", nq, 0);
        bus_write(A_FL + 16'd4, 16'hA500); window(np, nq);
        check(nq == 4, "R7 bad key", nq, 4);
        rd(A_FLAG, d); check(d == 16'h0010, "R10 flash flag", d, 16'h10);
    endtask

    task automatic t_fetch_one(input logic [15:0] a, input int exp, input string req);
        int np, nq;
        @(negedge clk); fetch_valid_i = 1; fetch_addr_i = a;
        @(negedge clk); fetch_valid_i = 0; fetch_addr_i = 16'hF000; window(np, nq);
        check(nq == exp, req, nq, exp);
    endtask

    task automatic t_fetch();
        t_fetch_one(16'h0100, 4, "R8 peripheral fetch");
        t_fetch_one(16'h0C00, 4, "R8 hole fetch");
        t_fetch_one(16'h0400, 0, "R8 ram fetch");
        t_fetch_one(16'hF000, 0, "R8 code fetch");
    endtask

    task automatic t_pin();
        int np, nq; logic [15:0] d;
        bus_write(A_FLAG, 16'h003F);
        @(negedge clk); rst_pin_n_i = 0;
        @(negedge clk); rst_pin_n_i = 1; window(np, nq);
        check(np == 4, "R2 pin hard reset", np, 4);
        check(nq == np, "R4 soft equals hard", nq, np);
        bus_write(A_CFG, 16'h0001);
        rd(A_CFG, d); check(d == 16'h0001, "R2 mode written", d, 1);
        @(negedge clk); rst_pin_n_i = 0;
        @(negedge clk); rst_pin_n_i = 1; window(np, nq);
        check(np == 0 && nq == 0, "R2 pin ignored in other mode", {np, nq}, 0);
        @(negedge clk); wdt_expire_i = 1;
        @(negedge clk); wdt_expire_i = 0; window(np, nq);
        rd(A_CFG, d); check(d == 16'h0000, "R12 mode back to reset", d, 0);
        rd(A_FLAG, d); check(d == 16'h000A, "R10 pin flag survives soft reset", d, 16'hA);
        bus_write(A_FLAG, 16'h0002);
        rd(A_FLAG, d); check(d == 16'h0008, "R11 clear one flag only", d, 8);
    endtask

    task automatic t_svs();
        int np, nq;
        @(negedge clk); sv_low_i = 1;
        @(negedge clk); sv_low_i = 0; window(np, nq);
        check(np == 0 && nq == 0, "R3 disabled", {np, nq}, 0);
        sv_rst_en_i = 1;
        @(negedge clk); sv_low_i = 1;
        @(negedge clk); sv_low_i = 0; window(np, nq);
        check(np == 4, "R3 enabled", np, 4);
        sv_rst_en_i = 0;
    endtask

    task automatic t_same_cycle();
        int np, nq; logic [15:0] d;
        bus_write(A_FLAG, 16'h003F);
        @(negedge clk); wdt_expire_i = 1; wr_en_i = 1; wr_addr_i = A_FLAG; wr_data_i = 16'h0008;
        @(negedge clk); wdt_expire_i = 0; wr_en_i = 0; window(np, nq);
        rd(A_FLAG, d); check(d[3] == 1'b1, "R11 set wins over clear", d, 8);
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_power();
        t_wdt_key();
        t_wdt_expire();
        t_flash();
        t_fetch();
        t_pin();
        t_svs();
        t_same_cycle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule